// File: doc/BRIEF.md
# Tag and Force Breakpoint Controller

This block turns a qualified debug trigger into a CPU breakpoint action at the right point in the instruction stream. Comparator results reach it as strobes: a general trigger and a separate comparator-A address hit. A small instruction queue tracks opcodes from fetch (push) to execution (pop). Each queue entry carries a mark bit. A breakpoint is either a tag mark that travels with an opcode until that opcode reaches the head, or a forced stop taken at the next instruction-boundary strobe.

When the break fires, the block raises a one-cycle background-entry request, or a software-interrupt request if background debug is disabled. A tagged opcode is never reported as executed: the break takes its place. A flush empties the queue and drops every mark, so prefetched opcodes that are discarded cannot cause a break.

The control state machine has three states. IDLE has no request outstanding. TAG_ARM holds a tag request until an opcode is accepted into the queue. FORCE_ARM holds a force request until a boundary strobe.

The transitions are:
- IDLE→TAG_ARM: tag request with no accepted push.
- IDLE→IDLE (mark): tag request together with an accepted push.
- IDLE→FORCE_ARM: force request.
- TAG_ARM→IDLE: accepted push, which is then marked.
- FORCE_ARM→IDLE: boundary strobe, which fires the break.

Top module: `dbg_brk_ctrl`

## Requirements
- R1: While the enable input `brk_en_i` is 0, triggers create no request: the controller stays idle and opcodes execute normally.
- R2: With tag type selected (`tag_sel_i`=1), a request marks the opcode accepted into the queue in the same cycle. If no opcode is accepted in that cycle, the request marks the next accepted opcode.
- R3: Popping a marked head entry produces a break pulse on the next cycle instead of an execute pulse for that opcode. Popping an unmarked entry gives `exec_valid_o` with its opcode on the next cycle.
- R4: With force type selected (`tag_sel_i`=0), a request is held until the first `boundary_i` strobe in a later cycle. A strobe in the request cycle does not count. The break pulse follows that strobe by one cycle.
- R5: A break pulse appears on `bgnd_req_o` if `bdm_en_i` is 1 in the firing cycle, and on `swi_req_o` if it is 0.
- R6: In mode codes 3 and 4 (the full-match modes) with tag type, only `cmpa_hit_i` forms the request and `trig_i` is ignored. In every other case `trig_i` forms the request and `cmpa_hit_i` is ignored.
- R7: `flush_i` empties the queue and clears all marks in the same clock edge. Flush has priority over push and pop.
- R8: A request yields exactly one break. Requests that arrive while a tag or force request is pending are ignored.
- R9: The queue holds DEPTH entries. A push to a full queue without a pop is dropped, and a pop of an empty queue has no effect.
- R10: `bgnd_req_o` and `swi_req_o` are never high together, and each break is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Qualified trigger strobe from the comparators |
| cmpa_hit_i | input | 1 | Comparator-A address match strobe |
| mode_i | input | MODE_W | Trigger mode code (3 and 4 are the full-match modes) |
| brk_en_i | input | 1 | Breakpoint enable |
| tag_sel_i | input | 1 | 1 selects tag type, 0 selects force type |
| bdm_en_i | input | 1 | Background debug enabled |
| push_i | input | 1 | Opcode enters the queue |
| push_op_i | input | OP_W | Opcode being pushed |
| pop_i | input | 1 | Head opcode reaches execution |
| flush_i | input | 1 | Discard the queue contents |
| boundary_i | input | 1 | Instruction-boundary strobe |
| exec_valid_o | output | 1 | Head opcode executed (one-cycle pulse) |
| exec_op_o | output | OP_W | Executed opcode |
| bgnd_req_o | output | 1 | Background-entry request pulse |
| swi_req_o | output | 1 | Software-interrupt request pulse |

## Verification
The bench uses the default parameters: a 3-entry queue, 8-bit opcodes and full-match mode codes 3 and 4. A shallow queue lets four back-to-back pushes reach the dropped-push case, and a short drain reaches the empty-pop case. The 8-bit opcodes give each pushed entry a distinct value, so the scoreboard can tell which opcode a marked break replaced. Both full-match codes are driven against a non-full code, with the trigger and the comparator-A hit set in opposite combinations.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_TAG_ARM   = 2'd1,
        ST_FORCE_ARM = 2'd2
    } brk_state_e;

    // Returns 1 when the mode code is one of the two full-match codes.
    function automatic logic is_full_mode(
        input logic [7:0] code,
        input logic [7:0] full_and,
        input logic [7:0] full_nand
    );
        return (code == full_and) || (code == full_nand);
    endfunction

endpackage

// File: rtl/dbg_brk_qual.sv
module dbg_brk_qual #(
    parameter int MODE_W    = 3,
    parameter int FULL_AND  = 3,
    parameter int FULL_NAND = 4
) (
    input  logic              trig_i,
    input  logic              cmpa_hit_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              brk_en_i,
    input  logic              tag_sel_i,
    output logic              req_o
);
    import dbg_brk_pkg::*;

    localparam logic [7:0] CODE_AND  = 8'(FULL_AND);
    localparam logic [7:0] CODE_NAND = 8'(FULL_NAND);

    logic full_w;
    logic src_w;

    always_comb begin
        full_w = is_full_mode(8'(mode_i), CODE_AND, CODE_NAND);
        // In the full-match modes a tag uses the address match alone.
        if (full_w && tag_sel_i) begin
            src_w = cmpa_hit_i;
        end else begin
            src_w = trig_i;
        end
        req_o = brk_en_i && src_w;
    end

endmodule

// File: rtl/dbg_brk_queue.sv
module dbg_brk_queue #(
    parameter int OP_W  = 8,
    parameter int DEPTH = 3,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [OP_W-1:0]  push_op_i,
    input  logic             mark_i,
    input  logic             pop_i,
    input  logic             flush_i,
    output logic             push_ok_o,
    output logic             pop_ok_o,
    output logic [OP_W-1:0]  head_op_o,
    output logic             head_tag_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [OP_W-1:0]  op_q   [DEPTH];
    logic [DEPTH-1:0] tag_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] wr_idx;
    logic             pop_ok;
    logic             push_ok;

    logic [OP_W-1:0]  src_op [DEPTH];
    logic [DEPTH-1:0] src_tag;

    always_comb begin
        pop_ok  = pop_i && (cnt_q != '0) && !flush_i;
        push_ok = push_i && !flush_i && ((cnt_q != FULL_CNT) || pop_ok);
        wr_idx  = cnt_q - CNT_W'(pop_ok);
        if (flush_i) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    // Each slot shifts toward the head on a pop and is loaded on a push
    // whose target index is its own.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [CNT_W-1:0] IDX = CNT_W'(g);

        if (g < DEPTH - 1) begin : g_mid
            assign src_op[g]  = op_q[g+1];
            assign src_tag[g] = tag_q[g+1];
        end else begin : g_last
            assign src_op[g]  = '0;
            assign src_tag[g] = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                op_q[g]  <= '0;
                tag_q[g] <= 1'b0;
            end else if (flush_i) begin
                tag_q[g] <= 1'b0;
            end else if (push_ok && (wr_idx == IDX)) begin
                op_q[g]  <= push_op_i;
                tag_q[g] <= mark_i;
            end else if (pop_ok) begin
                op_q[g]  <= src_op[g];
                tag_q[g] <= src_tag[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign push_ok_o  = push_ok;
    assign pop_ok_o   = pop_ok;
    assign head_op_o  = op_q[0];
    assign head_tag_o = tag_q[0] && (cnt_q != '0);
    assign cnt_o      = cnt_q;

endmodule

// File: rtl/dbg_brk_fsm.sv
module dbg_brk_fsm (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  logic                    tag_sel_i,
    input  logic                    push_ok_i,
    input  logic                    boundary_i,
    output logic                    mark_o,
    output logic                    force_fire_o,
    output dbg_brk_pkg::brk_state_e state_o
);
    import dbg_brk_pkg::*;

    brk_state_e state_q;
    brk_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d      = state_q;
        mark_o       = 1'b0;
        force_fire_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    if (tag_sel_i) begin
                        if (push_ok_i) begin
                            mark_o = 1'b1;
                        end else begin
                            state_d = ST_TAG_ARM;
                        end
                    end else begin
                        state_d = ST_FORCE_ARM;
                    end
                end
            end
            ST_TAG_ARM: begin
                if (push_ok_i) begin
                    mark_o  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_FORCE_ARM: begin
                if (boundary_i) begin
                    force_fire_o = 1'b1;
                    state_d      = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/dbg_brk_out.sv
module dbg_brk_out #(
    parameter int OP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pop_ok_i,
    input  logic            head_tag_i,
    input  logic [OP_W-1:0] head_op_i,
    input  logic            force_fire_i,
    input  logic            bdm_en_i,
    output logic            exec_valid_o,
    output logic [OP_W-1:0] exec_op_o,
    output logic            bgnd_req_o,
    output logic            swi_req_o
);
    logic fire_w;
    logic tag_fire_w;

    always_comb begin
        tag_fire_w = pop_ok_i && head_tag_i;
        fire_w     = tag_fire_w || force_fire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_valid_o <= 1'b0;
            exec_op_o    <= '0;
            bgnd_req_o   <= 1'b0;
            swi_req_o    <= 1'b0;
        end else begin
            exec_valid_o <= pop_ok_i && !head_tag_i;
            if (pop_ok_i) begin
                exec_op_o <= head_op_i;
            end
            bgnd_req_o <= fire_w && bdm_en_i;
            swi_req_o  <= fire_w && !bdm_en_i;
        end
    end

endmodule

// File: rtl/dbg_brk_ctrl.sv
module dbg_brk_ctrl #(
    parameter int OP_W      = 8,
    parameter int DEPTH     = 3,
    parameter int MODE_W    = 3,
    parameter int FULL_AND  = 3,
    parameter int FULL_NAND = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              cmpa_hit_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              brk_en_i,
    input  logic              tag_sel_i,
    input  logic              bdm_en_i,
    input  logic              push_i,
    input  logic [OP_W-1:0]   push_op_i,
    input  logic              pop_i,
    input  logic              flush_i,
    input  logic              boundary_i,
    output logic              exec_valid_o,
    output logic [OP_W-1:0]   exec_op_o,
    output logic              bgnd_req_o,
    output logic              swi_req_o
);
    import dbg_brk_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             req_w;
    logic             mark_w;
    logic             force_fire_w;
    logic             push_ok_w;
    logic             pop_ok_w;
    logic [OP_W-1:0]  head_op_w;
    logic             head_tag_w;
    logic [CNT_W-1:0] q_cnt_w;
    brk_state_e       state_w;

    dbg_brk_qual #(
        .MODE_W    (MODE_W),
        .FULL_AND  (FULL_AND),
        .FULL_NAND (FULL_NAND)
    ) u_qual (
        .trig_i     (trig_i),
        .cmpa_hit_i (cmpa_hit_i),
        .mode_i     (mode_i),
        .brk_en_i   (brk_en_i),
        .tag_sel_i  (tag_sel_i),
        .req_o      (req_w)
    );

    dbg_brk_queue #(
        .OP_W  (OP_W),
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_i),
        .push_op_i  (push_op_i),
        .mark_i     (mark_w),
        .pop_i      (pop_i),
        .flush_i    (flush_i),
        .push_ok_o  (push_ok_w),
        .pop_ok_o   (pop_ok_w),
        .head_op_o  (head_op_w),
        .head_tag_o (head_tag_w),
        .cnt_o      (q_cnt_w)
    );

    dbg_brk_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_w),
        .tag_sel_i    (tag_sel_i),
        .push_ok_i    (push_ok_w),
        .boundary_i   (boundary_i),
        .mark_o       (mark_w),
        .force_fire_o (force_fire_w),
        .state_o      (state_w)
    );

    dbg_brk_out #(
        .OP_W (OP_W)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .pop_ok_i     (pop_ok_w),
        .head_tag_i   (head_tag_w),
        .head_op_i    (head_op_w),
        .force_fire_i (force_fire_w),
        .bdm_en_i     (bdm_en_i),
        .exec_valid_o (exec_valid_o),
        .exec_op_o    (exec_op_o),
        .bgnd_req_o   (bgnd_req_o),
        .swi_req_o    (swi_req_o)
    );

endmodule

// File: rtl/dbg_brk_chk.sv
module dbg_brk_chk #(
    parameter int DEPTH = 3,
    parameter int CNT_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input dbg_brk_pkg::brk_state_e state,
    input logic [CNT_W-1:0]        cnt,
    input logic                    brk_en,
    input logic                    pop_ok,
    input logic                    head_tag,
    input logic                    boundary,
    input logic                    flush,
    input logic                    bdm_en,
    input logic                    exec_valid,
    input logic                    bgnd,
    input logic                    swi
);
    import dbg_brk_pkg::*;

    // R10
    no_dual_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bgnd && swi));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !brk_en) |=> (state == ST_IDLE));

    // R3
    tag_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && head_tag) |=> ((bgnd || swi) && !exec_valid));

    // R4
    force_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FORCE_ARM && boundary) |=> (bgnd || swi));

    // R5
    swi_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swi |-> !$past(bdm_en));

    // R9
    depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0 && !head_tag));

endmodule

bind dbg_brk_ctrl dbg_brk_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_w),
    .cnt        (q_cnt_w),
    .brk_en     (brk_en_i),
    .pop_ok     (pop_ok_w),
    .head_tag   (head_tag_w),
    .boundary   (boundary_i),
    .flush      (flush_i),
    .bdm_en     (bdm_en_i),
    .exec_valid (exec_valid_o),
    .bgnd       (bgnd_req_o),
    .swi        (swi_req_o)
);

// File: tb/dbg_brk_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_brk_ctrl_bench;

    localparam int K_EXEC = 0;
    localparam int K_BGND = 1;
    localparam int K_SWI  = 2;
    localparam int K_NONE = -1;

    typedef struct {
        int         kind;
        logic [7:0] op;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_i = 1'b0;
    logic       cmpa_hit_i = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic       brk_en_i = 1'b0;
    logic       tag_sel_i = 1'b0;
    logic       bdm_en_i = 1'b1;
    logic       push_i = 1'b0;
    logic [7:0] push_op_i = 8'h00;
    logic       pop_i = 1'b0;
    logic       flush_i = 1'b0;
    logic       boundary_i = 1'b0;
    logic       exec_valid_o;
    logic [7:0] exec_op_o;
    logic       bgnd_req_o;
    logic       swi_req_o;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    dbg_brk_ctrl u_dbg_brk_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_i),
        .cmpa_hit_i   (cmpa_hit_i),
        .mode_i       (mode_i),
        .brk_en_i     (brk_en_i),
        .tag_sel_i    (tag_sel_i),
        .bdm_en_i     (bdm_en_i),
        .push_i       (push_i),
        .push_op_i    (push_op_i),
        .pop_i        (pop_i),
        .flush_i      (flush_i),
        .boundary_i   (boundary_i),
        .exec_valid_o (exec_valid_o),
        .exec_op_o    (exec_op_o),
        .bgnd_req_o   (bgnd_req_o),
        .swi_req_o    (swi_req_o)
    );

    function automatic string kname(input int k);
        case (k)
            K_EXEC:  return "EXEC";
            K_BGND:  return "BGND";
            K_SWI:   return "SWI";
            default: return "BOTH";
        endcase
    endfunction

    // Monitor: compare each produced action against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int obs;
            obs = K_NONE;
            if (bgnd_req_o && swi_req_o) obs = 9;
            else if (bgnd_req_o)         obs = K_BGND;
            else if (swi_req_o)          obs = K_SWI;
            if (exec_valid_o) begin
                if (obs != K_NONE) obs = 9;
                else               obs = K_EXEC;
            end
            if (obs != K_NONE) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R10 unexpected action: actual %s op=%h expected none",
                             kname(obs), exec_op_o);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (obs != e.kind || (obs == K_EXEC && exec_op_o != e.op)) begin
                        n_fail++;
                        $display("FAIL %s: actual %s op=%h expected %s op=%h",
                                 e.req, kname(obs), exec_op_o, kname(e.kind), e.op);
                    end
                end
            end
        end
    end

    task automatic expect_item(input int kind, input logic [7:0] op, input string rq);
        exp_t e;
        e.kind = kind;
        e.op   = op;
        e.req  = rq;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_push(input logic [7:0] op, input logic t, input logic c);
        push_i     = 1'b1;
        push_op_i  = op;
        trig_i     = t;
        cmpa_hit_i = c;
        @(negedge clk);
        push_i     = 1'b0;
        trig_i     = 1'b0;
        cmpa_hit_i = 1'b0;
    endtask

    task automatic do_pop(input int kind, input logic [7:0] op, input string rq);
        if (kind != K_NONE) expect_item(kind, op, rq);
        pop_i = 1'b1;
        @(negedge clk);
        pop_i = 1'b0;
        idle(1);
    endtask

    task automatic do_trig(input logic bnd);
        trig_i     = 1'b1;
        boundary_i = bnd;
        @(negedge clk);
        trig_i     = 1'b0;
        boundary_i = 1'b0;
    endtask

    task automatic do_boundary(input int kind, input string rq);
        if (kind != K_NONE) expect_item(kind, 8'h00, rq);
        boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
        idle(1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // Reset state: all action outputs low.
        n_chk++;
        if (exec_valid_o || bgnd_req_o || swi_req_o) begin
            n_fail++;
            $display("FAIL reset: actual %b%b%b expected 000",
                     exec_valid_o, bgnd_req_o, swi_req_o);
        end

        // R1: enable low, trigger ignored, opcode executes.
        brk_en_i = 1'b0; tag_sel_i = 1'b1;
        do_push(8'h11, 1'b1, 1'b1);
        do_trig(1'b1);
        do_pop(K_EXEC, 8'h11, "R1");
        do_boundary(K_NONE, "R1");

        // R2, R3: same-cycle tag marks the entering opcode.
        brk_en_i = 1'b1; tag_sel_i = 1'b1; bdm_en_i = 1'b1; mode_i = 3'd0;
        do_push(8'h21, 1'b0, 1'b0);
        do_push(8'h22, 1'b1, 1'b0);
        do_push(8'h23, 1'b0, 1'b0);
        do_pop(K_EXEC, 8'h21, "R3");
        do_pop(K_BGND, 8'h22, "R2");
        do_pop(K_EXEC, 8'h23, "R3");

        // R2: request without push marks the next pushed opcode.
        do_trig(1'b0);
        idle(2);
        do_push(8'h31, 1'b0, 1'b0);
        do_push(8'h32, 1'b0, 1'b0);
        do_pop(K_BGND, 8'h31, "R2");
        do_pop(K_EXEC, 8'h32, "R2");

        // R6: full-match modes use comparator A alone for tags.
        mode_i = 3'd3;
        do_push(8'h41, 1'b1, 1'b0);
        do_push(8'h42, 1'b0, 1'b1);
        do_pop(K_EXEC, 8'h41, "R6");
        do_pop(K_BGND, 8'h42, "R6");
        mode_i = 3'd0;
        do_push(8'h43, 1'b0, 1'b1);
        do_pop(K_EXEC, 8'h43, "R6");
        mode_i = 3'd4;
        do_push(8'h44, 1'b0, 1'b1);
        do_pop(K_BGND, 8'h44, "R6");
        mode_i = 3'd0;

        // R5: background debug disabled gives a software interrupt.
        bdm_en_i = 1'b0;
        do_push(8'h51, 1'b1, 1'b0);
        do_pop(K_SWI, 8'h51, "R5");
        bdm_en_i = 1'b1;

        // R4: force waits for a later boundary strobe.
        tag_sel_i = 1'b0;
        do_trig(1'b1);
        idle(3);
        do_boundary(K_BGND, "R4");
        do_trig(1'b0);
        idle(2);
        bdm_en_i = 1'b0;
        do_boundary(K_SWI, "R5");
        bdm_en_i = 1'b1;

        // R8: one action per request, extra requests ignored.
        do_trig(1'b0);
        do_trig(1'b0);
        do_boundary(K_BGND, "R8");
        do_boundary(K_NONE, "R8");
        tag_sel_i = 1'b1;
        do_trig(1'b0);
        do_trig(1'b0);
        do_push(8'h71, 1'b0, 1'b0);
        do_push(8'h72, 1'b0, 1'b0);
        do_pop(K_BGND, 8'h71, "R8");
        do_pop(K_EXEC, 8'h72, "R8");

        // R7: flush drops marked entries.
        do_push(8'h81, 1'b1, 1'b0);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        do_push(8'h82, 1'b0, 1'b0);
        do_pop(K_EXEC, 8'h82, "R7");
        do_pop(K_NONE, 8'h00, "R7");

        // R9: depth limit, push when full dropped, pop when empty ignored.
        do_push(8'h91, 1'b0, 1'b0);
        do_push(8'h92, 1'b0, 1'b0);
        do_push(8'h93, 1'b0, 1'b0);
        do_push(8'h94, 1'b0, 1'b0);
        do_pop(K_EXEC, 8'h91, "R9");
        do_pop(K_EXEC, 8'h92, "R9");
        do_pop(K_EXEC, 8'h93, "R9");
        do_pop(K_NONE, 8'h00, "R9");
        idle(3);

        // R10: every expected action was produced exactly once.
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 missing actions: actual %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule